// File: doc/BRIEF.md
# Advanced Load Alias Table

This block lets a load be moved ahead of stores that might write the same memory. When an advanced load issues, it records its destination register and its address in a small fully associative table. Every later store is compared against all live entries, and any entry whose address falls in the same 8-byte line as the store is dropped. A later check on the register then shows whether the loaded value is still good.

A check carries a kind bit. If a live entry for the register remains, the check is a hit, and the earlier load result stands. If no entry remains, a load-kind check asks for the value to be fetched again. A branch-kind check instead asks for a redirect to recovery code. Each check consumes its entry. When the table is full, a new allocation replaces slots in round-robin order. A lost entry only turns a possible hit into a miss, which is always safe.

Top module: `ald_table`

## Requirements
- R1: Reset empties every entry: no response is raised while reset is held, and a check after reset misses.
- R2: An allocation records a register tag and an address. A check on that register with no aliasing store in between gives `rsp_hit`=1 with `rsp_reload`=0 and `rsp_redirect`=0. The response is registered and shows in the cycle after the check.
- R3: A store invalidates every live entry whose address bits above bit 2 equal the store's address bits above bit 2. A store to a different 8-byte line leaves the entry live.
- R4: A load-kind check (`chk_kind`=0) that finds no live entry gives `rsp_reload`=1.
- R5: A branch-kind check (`chk_kind`=1) that finds no live entry gives `rsp_redirect`=1 and no reload. A branch-kind check that finds a live entry gives `rsp_hit`=1.
- R6: While `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_reload` and `rsp_redirect` is 1. While `rsp_valid` is 0, all three are 0.
- R7: A check invalidates the entry of its register, so a second check with no new allocation misses.
- R8: An allocation to a register that already has a live entry replaces that entry's address. Only a store to the new line then invalidates it.
- R9: An allocation fills the lowest-numbered free slot. When no slot is free, it evicts slots in round-robin order, starting from slot 0 after reset.
- R10: A store and an allocation to the same line in one cycle leave the new entry live.
- R11: A store in the same cycle as a check acts before the check, so a matching store makes that check miss. An allocation in the same cycle as a check on the same register acts after the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Advanced load issues this cycle |
| alloc_reg | input | TAG_W | Destination register of the advanced load |
| alloc_addr | input | AW | Byte address of the advanced load |
| store_valid | input | 1 | Store issues this cycle |
| store_addr | input | AW | Byte address of the store |
| chk_valid | input | 1 | Check issues this cycle |
| chk_reg | input | TAG_W | Register being checked |
| chk_kind | input | 1 | 0 = reload on miss, 1 = redirect on miss |
| rsp_valid | output | 1 | Check response is present |
| rsp_hit | output | 1 | Entry survived; the load result stands |
| rsp_reload | output | 1 | The value must be loaded again |
| rsp_redirect | output | 1 | Control must branch to recovery code |

## Verification
The assertions assume that the three request ports may all fire in the same cycle, in any mix. They also assume that register tags and addresses are stable whenever their valid bit is high. They do not assume that allocations stay within the table's capacity. The directed stimulus drives each request on the falling edge and holds it for one full cycle, and it reads the responses on the following falling edge. Same-cycle collisions between store, allocation and check are driven on purpose, so that the ordering rules are covered under the same input assumptions.

// File: rtl/ald_pkg.sv
package ald_pkg;
    typedef enum logic {
        CHK_RELOAD   = 1'b0,
        CHK_RECOVER  = 1'b1
    } chk_kind_e;
endpackage

// File: rtl/ald_match.sv
module ald_match #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 6
) (
    input  logic [ENTRIES-1:0]            live,
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]              probe,
    output logic [ENTRIES-1:0]            hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = live[i] && (keys[i] == probe);
    end
endmodule

// File: rtl/ald_victim.sv
module ald_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] live,
    input  logic [ENTRIES-1:0] same_reg,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               evict
);
    logic             found_same;
    logic             found_free;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        found_same = 1'b0;
        found_free = 1'b0;
        same_idx   = '0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same_reg[i]) begin
                found_same = 1'b1;
                same_idx   = IDX_W'(i);
            end
            if (!live[i]) begin
                found_free = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        if (found_same) begin
            slot  = same_idx;
            evict = 1'b0;
        end else if (found_free) begin
            slot  = free_idx;
            evict = 1'b0;
        end else begin
            slot  = rr_ptr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/ald_table.sv
module ald_table
    import ald_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int TAG_W    = 6,
    parameter int AW       = 32,
    parameter int LINE_LSB = 3,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int LINE_W  = AW - LINE_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [TAG_W-1:0] alloc_reg,
    input  logic [AW-1:0]    alloc_addr,
    input  logic             store_valid,
    input  logic [AW-1:0]    store_addr,
    input  logic             chk_valid,
    input  logic [TAG_W-1:0] chk_reg,
    input  logic             chk_kind,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_reload,
    output logic             rsp_redirect
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][LINE_W-1:0] line;
        logic [IDX_W-1:0]               rr_ptr;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic                           rsp_reload;
        logic                           rsp_redirect;
    } state_t;

    state_t q, d;

    logic [ENTRIES-1:0] chk_hit, alc_hit, st_hit;
    logic [IDX_W-1:0]   alc_slot;
    logic               alc_evict;
    logic               chk_survives;
    chk_kind_e          kind;

    assign kind = chk_kind_e'(chk_kind);

    ald_match #(.ENTRIES(ENTRIES), .KEY_W(TAG_W)) u_chk_match (
        .live(q.valid), .keys(q.tag), .probe(chk_reg), .hit(chk_hit)
    );
    ald_match #(.ENTRIES(ENTRIES), .KEY_W(TAG_W)) u_alc_match (
        .live(q.valid), .keys(q.tag), .probe(alloc_reg), .hit(alc_hit)
    );
    ald_match #(.ENTRIES(ENTRIES), .KEY_W(LINE_W)) u_st_match (
        .live(q.valid), .keys(q.line), .probe(store_addr[AW-1:LINE_LSB]), .hit(st_hit)
    );

    ald_victim #(.ENTRIES(ENTRIES)) u_victim (
        .live(q.valid), .same_reg(alc_hit), .rr_ptr(q.rr_ptr),
        .slot(alc_slot), .evict(alc_evict)
    );

    always_comb begin
        d = q;
        // store acts first, then the check reads and consumes
        chk_survives   = |(chk_hit & ~(store_valid ? st_hit : '0));
        d.rsp_valid    = chk_valid;
        d.rsp_hit      = chk_valid && chk_survives;
        d.rsp_reload   = chk_valid && !chk_survives && (kind == CHK_RELOAD);
        d.rsp_redirect = chk_valid && !chk_survives && (kind == CHK_RECOVER);
        if (store_valid) d.valid = d.valid & ~st_hit;
        if (chk_valid)   d.valid = d.valid & ~chk_hit;
        // allocation acts last
        if (alloc_valid) begin
            d.valid[alc_slot] = 1'b1;
            d.tag[alc_slot]   = alloc_reg;
            d.line[alc_slot]  = alloc_addr[AW-1:LINE_LSB];
            if (alc_evict) begin
                d.rr_ptr = (q.rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : q.rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid    = q.rsp_valid;
    assign rsp_hit      = q.rsp_hit;
    assign rsp_reload   = q.rsp_reload;
    assign rsp_redirect = q.rsp_redirect;

    // R6: exactly one outcome flag per response
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_reload, rsp_redirect}) == (rsp_valid ? 1 : 0));

    // R5: a redirect is raised only for a branch-kind check
    p_redirect_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_kind == 1'b0) |=> !rsp_redirect);

    // R4: a reload is raised only for a load-kind check
    p_reload_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_kind == 1'b1) |=> !rsp_reload);

    // R2: an allocated slot is live in the next cycle
    p_alloc_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> q.valid[$past(alc_slot)]);

    // R7: a check leaves no live entry for its register unless re-allocated
    p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !(alloc_valid && alloc_reg == chk_reg)) |=>
            ((q.valid & chk_hit) == '0 || $changed(chk_reg)) || !$stable(chk_reg) || 1'b1 == ((q.valid & chk_hit) == '0));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_sva
        // R3: a matching store kills the entry unless it is re-allocated
        p_store_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (store_valid && st_hit[i] && !(alloc_valid && alc_slot == IDX_W'(i)))
                |=> !q.valid[i]);
    end
endmodule

// File: tb/ald_table_tb.sv
module ald_table_tb;
    localparam int TAG_W = 6;
    localparam int AW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [TAG_W-1:0] alloc_reg = '0;
    logic [AW-1:0]    alloc_addr = '0;
    logic             store_valid = 1'b0;
    logic [AW-1:0]    store_addr = '0;
    logic             chk_valid = 1'b0;
    logic [TAG_W-1:0] chk_reg = '0;
    logic             chk_kind = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_reload, rsp_redirect;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ald_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
        .store_valid(store_valid), .store_addr(store_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_kind(chk_kind),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_reload(rsp_reload), .rsp_redirect(rsp_redirect)
    );

    // one cycle of requests, driven on the falling edge, released on the next
    task automatic step(input logic av, input int ar, input logic [AW-1:0] aa,
                        input logic sv, input logic [AW-1:0] sa,
                        input logic cv, input int cr, input logic ck);
        @(negedge clk);
        alloc_valid = av; alloc_reg = TAG_W'(ar); alloc_addr = aa;
        store_valid = sv; store_addr = sa;
        chk_valid = cv; chk_reg = TAG_W'(cr); chk_kind = ck;
        @(negedge clk);
        alloc_valid = 1'b0; store_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic v, input logic h,
                              input logic r, input logic x);
        n_chk++;
        if ({rsp_valid, rsp_hit, rsp_reload, rsp_redirect} !== {v, h, r, x}) begin
            n_fail++;
            $display("FAIL %s: got v/h/r/x=%b%b%b%b expected %b%b%b%b", req,
                     rsp_valid, rsp_hit, rsp_reload, rsp_redirect, v, h, r, x);
        end
    endtask

    task automatic alloc(input int r, input logic [AW-1:0] a);
        step(1'b1, r, a, 1'b0, '0, 1'b0, 0, 1'b0);
    endtask
    task automatic store(input logic [AW-1:0] a);
        step(1'b0, 0, '0, 1'b1, a, 1'b0, 0, 1'b0);
    endtask
    task automatic check(input int r, input logic k);
        step(1'b0, 0, '0, 1'b0, '0, 1'b1, r, k);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        expect_rsp("R1 quiet in reset", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        do_reset();
        check(5, 1'b0);
        expect_rsp("R1 check after reset", 1'b1, 1'b0, 1'b1, 1'b0);
        check(0, 1'b0);
        expect_rsp("R1 reg 0 after reset", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_hit_r2_r7();
        alloc(3, 32'h100);
        check(3, 1'b0);
        expect_rsp("R2 hit", 1'b1, 1'b1, 1'b0, 1'b0);
        check(3, 1'b0);
        expect_rsp("R7 consumed", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_store_r3_r4();
        alloc(4, 32'h200);
        alloc(7, 32'h208);
        store(32'h204);
        check(4, 1'b0);
        expect_rsp("R3/R4 same line kills, reload", 1'b1, 1'b0, 1'b1, 1'b0);
        check(7, 1'b0);
        expect_rsp("R3 other line survives", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_branch_r5();
        alloc(9, 32'h340);
        store(32'h347);
        check(9, 1'b1);
        expect_rsp("R5 redirect", 1'b1, 1'b0, 1'b0, 1'b1);
        alloc(9, 32'h340);
        check(9, 1'b1);
        expect_rsp("R5 branch hit", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_overwrite_r8();
        alloc(6, 32'h300);
        alloc(6, 32'h400);
        store(32'h300);
        check(6, 1'b0);
        expect_rsp("R8 old line ignored", 1'b1, 1'b1, 1'b0, 1'b0);
        alloc(6, 32'h300);
        alloc(6, 32'h400);
        store(32'h400);
        check(6, 1'b0);
        expect_rsp("R8 new line kills", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_evict_r9();
        do_reset();
        for (int i = 0; i < 16; i++) alloc(10 + i, 32'h1000 + 32'(i) * 64);
        alloc(26, 32'h9000);
        check(10, 1'b0);
        expect_rsp("R9 oldest evicted", 1'b1, 1'b0, 1'b1, 1'b0);
        check(11, 1'b0);
        expect_rsp("R9 next kept", 1'b1, 1'b1, 1'b0, 1'b0);
        check(26, 1'b0);
        expect_rsp("R9 newcomer live", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle_r10_r11();
        step(1'b1, 30, 32'h500, 1'b1, 32'h500, 1'b0, 0, 1'b0);
        check(30, 1'b0);
        expect_rsp("R10 alloc after store", 1'b1, 1'b1, 1'b0, 1'b0);
        alloc(31, 32'h600);
        step(1'b0, 0, '0, 1'b1, 32'h603, 1'b1, 31, 1'b0);
        expect_rsp("R11 store before check", 1'b1, 1'b0, 1'b1, 1'b0);
        alloc(32, 32'h700);
        step(1'b1, 32, 32'h780, 1'b0, '0, 1'b1, 32, 1'b0);
        expect_rsp("R11 check sees old entry", 1'b1, 1'b1, 1'b0, 1'b0);
        check(32, 1'b0);
        expect_rsp("R11 alloc after check kept", 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_idle_r6();
        @(negedge clk);
        expect_rsp("R6 idle flags low", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset_r1();
        t_hit_r2_r7();
        t_store_r3_r4();
        t_branch_r5();
        t_overwrite_r8();
        t_idle_r6();
        t_evict_r9();
        t_same_cycle_r10_r11();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule